// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches 24 general-purpose input pins and reports level changes on them to the processor. The pins are split into three groups of eight. Every pin passes through a two-stage synchronizer. A change of either polarity on a pin that software has enabled sets that group's pending flag. One interrupt request line per group is driven while the group's flag is set, the group is enabled, and the global interrupt-enable input is high. All pins of a group share one flag and one request, so the handler cannot learn from the block which pin moved.

Software sets up the block through a small register port. It has one mask register per group, a group-enable register and a pending-flag register. A flag is cleared either by an acknowledge pulse from the interrupt controller for that group or by writing 1 to its bit. If a new change arrives in the same cycle as a clear, the flag stays set and the event is kept. The block carries no data stream, so every pin is a plain control or status signal and none has a handshake.

Top module: `pin_change_irq`

## Requirements
- R1: A rising or a falling level change on pin p, where mask bit p mod 8 of group p/8 is 1, sets pending flag bit p/8. The flag is visible on the third rising clock edge after the pin changes.
- R2: Group 1 has only seven pins (pins 8 to 14). Bit 7 of its mask reads 0 whatever is written, and a change on pin 15 never sets a flag.
- R3: After reset, all three masks, the group-enable register, the flags and `irq_o` are zero.
- R4: The register map is: address 0, 1 and 2 hold the masks of groups 0, 1 and 2; address 3 holds the group enables in bits 2:0 (bit g for group g); address 4 holds the flags in bits 2:0. In the group-enable register, bits 7:3 read 0.
- R5: A change on a pin whose mask bit is 0 leaves the flags unchanged.
- R6: `irq_o[g]` is high exactly when flag g, group-enable bit g and `glob_ie_i` are all 1.
- R7: With `glob_ie_i` low, every `irq_o` bit is 0. Flags still set and stay pending, and their requests appear once `glob_ie_i` rises.
- R8: An `ack_i[g]` pulse clears flag g. Writing 1 to bit g at address 4 clears flag g. Writing 0 leaves it unchanged.
- R9: A change detected in the same cycle as a clear of the same group leaves that flag set.
- R10: Groups are independent. A change in one group sets no other group's flag, and clearing one flag leaves the others as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 24 | Asynchronous pin levels; pin p is in group p/8 |
| glob_ie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Per-group acknowledge pulse from the interrupt controller |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
A pin change sets its flag on the third rising edge after the change: two edges pass through the synchronizer and one loads the flag. The bench drives each pin on a falling edge, waits three rising edges and samples on the next falling edge. Register writes and acknowledge pulses act on the next rising edge, so their results are sampled one falling edge later. `irq_o` and read data are combinational, so they are sampled a short delay after the inputs settle. For the coincidence case, the acknowledge is timed to fall in the very cycle whose edge loads the change.

// File: rtl/pcic_pkg.sv
package pcic_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADR_MASK0 = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_GEN   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_FLAG  = 3'd4;
endpackage

// File: rtl/pcic_sync.sv
module pcic_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcic_group.sv
module pcic_group #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  output logic         set_o,
  output logic         flag_o
);
  logic [W-1:0] prev_q;
  logic         flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  // any masked edge in the group
  assign set_o = |((sync_i ^ prev_q) & mask_i);

  // a new event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (set_o)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/pcic_regs.sv
module pcic_regs
  import pcic_pkg::*;
#(
  parameter int GROUPS = 3,
  parameter int GRP_W  = 8,
  parameter logic [GROUPS*GRP_W-1:0] IMPL = 24'hFF7FFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [GROUPS-1:0]       flags_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [GROUPS*GRP_W-1:0] masks_o,
  output logic [GROUPS-1:0]       gen_o,
  output logic [GROUPS-1:0]       wclr_o
);
  logic [GROUPS-1:0][GRP_W-1:0] mask_q;
  logic [GROUPS-1:0]            gen_q;

  for (genvar g = 0; g < GROUPS; g++) begin : g_mask
    localparam logic [ADDR_W-1:0] MY_ADR = ADR_MASK0 + ADDR_W'(g);
    localparam logic [GRP_W-1:0]  KEEP   = IMPL[g*GRP_W +: GRP_W];
    always_ff @(posedge clk) begin
      if (!rst_n)                        mask_q[g] <= '0;
      else if (wr_i && addr_i == MY_ADR) mask_q[g] <= wdata_i[GRP_W-1:0] & KEEP;
    end
    assign masks_o[g*GRP_W +: GRP_W] = mask_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         gen_q <= '0;
    else if (wr_i && addr_i == ADR_GEN) gen_q <= wdata_i[GROUPS-1:0];
  end

  assign gen_o  = gen_q;
  assign wclr_o = (wr_i && addr_i == ADR_FLAG) ? wdata_i[GROUPS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADR_GEN)       rdata_o[GROUPS-1:0] = gen_q;
    else if (addr_i == ADR_FLAG) rdata_o[GROUPS-1:0] = flags_i;
    else begin
      for (int g = 0; g < GROUPS; g++)
        if (addr_i == ADR_MASK0 + ADDR_W'(g)) rdata_o[GRP_W-1:0] = mask_q[g];
    end
  end
endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pcic_pkg::*;
#(
  parameter int GROUPS      = 3,
  parameter int GRP_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [GROUPS*GRP_W-1:0] IMPL = 24'hFF7FFF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GROUPS*GRP_W-1:0] pins_i,
  input  logic                    glob_ie_i,
  input  logic [GROUPS-1:0]       ack_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic                    reg_wr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output logic [GROUPS-1:0]       irq_o
);
  localparam int PINS = GROUPS * GRP_W;

  logic [PINS-1:0]   sync_w;
  logic [PINS-1:0]   masks_w;
  logic [GROUPS-1:0] gen_w, wclr_w, flags_w, set_w;

  pcic_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pins_i), .q_o(sync_w)
  );

  pcic_regs #(.GROUPS(GROUPS), .GRP_W(GRP_W), .IMPL(IMPL)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
    .wdata_i(reg_wdata_i), .flags_i(flags_w), .rdata_o(reg_rdata_o),
    .masks_o(masks_w), .gen_o(gen_w), .wclr_o(wclr_w)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    pcic_group #(.W(GRP_W)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .sync_i(sync_w[g*GRP_W +: GRP_W]),
      .mask_i(masks_w[g*GRP_W +: GRP_W]),
      .clr_i(ack_i[g] | wclr_w[g]),
      .set_o(set_w[g]), .flag_o(flags_w[g])
    );
  end

  assign irq_o = flags_w & gen_w & {GROUPS{glob_ie_i}};
endmodule

// File: rtl/pcic_checker.sv
module pcic_checker #(
  parameter int GROUPS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              glob_ie_i,
  input logic [GROUPS-1:0] irq_o,
  input logic [GROUPS-1:0] gen_w,
  input logic [GROUPS-1:0] flags_w,
  input logic [GROUPS-1:0] set_w,
  input logic [GROUPS-1:0] ack_i,
  input logic [2:0]        reg_addr_i,
  input logic [7:0]        reg_rdata_o
);
  assert_global_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_ie_i |-> irq_o == '0);

  assert_group_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~(gen_w & flags_w)) == '0);

  assert_gen_high_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr_i == 3'd3 |-> reg_rdata_o[7:3] == 5'd0);

  assert_mid_bit7_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr_i == 3'd1 |-> reg_rdata_o[7] == 1'b0);

  assert_event_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w != '0) |=> ((flags_w & $past(set_w)) == $past(set_w)));

  assert_rise_needs_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_w & ~$past(flags_w)) & ~$past(set_w)) == '0);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i & ~set_w) != '0 |=> (flags_w & $past(ack_i & ~set_w)) == '0);
endmodule

bind pin_change_irq pcic_checker #(.GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .glob_ie_i(glob_ie_i), .irq_o(irq_o),
  .gen_w(gen_w), .flags_w(flags_w), .set_w(set_w), .ack_i(ack_i),
  .reg_addr_i(reg_addr_i), .reg_rdata_o(reg_rdata_o)
);

// File: tb/test_pin_change_irq.sv
module test_pin_change_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] pins = '0;
  logic        gie = 1'b0;
  logic [2:0]  ack = '0;
  logic [2:0]  addr = '0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [2:0]  irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pin_change_irq i_pin_change_irq (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .glob_ie_i(gie), .ack_i(ack),
    .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic toggle(int p);
    @(negedge clk); pins[p] = ~pins[p];
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    wreg(3'd4, 8'h07);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int a = 0; a < 5; a++) begin
      rreg(a[2:0], d); chk("R3 reset reg", d, 8'h00);
    end
    chk("R3 reset irq", {5'd0, irq}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wreg(3'd3, 8'hFF); rreg(3'd3, d); chk("R4 gen upper bits", d, 8'h07);
    wreg(3'd1, 8'hFF); rreg(3'd1, d); chk("R2 mid mask bit7", d, 8'h7F);
    wreg(3'd0, 8'hA5); rreg(3'd0, d); chk("R4 mask0 readback", d, 8'hA5);
    wreg(3'd2, 8'h3C); rreg(3'd2, d); chk("R4 mask2 readback", d, 8'h3C);
  endtask

  task automatic t_edges();
    logic [7:0] d;
    wreg(3'd0, 8'h01); wreg(3'd1, 8'h40); wreg(3'd2, 8'h80);
    toggle(0); rreg(3'd4, d); chk("R1 rise pin0", d, 8'h01);
    clear_all();
    toggle(0); rreg(3'd4, d); chk("R1 fall pin0", d, 8'h01);
    clear_all();
    toggle(14); rreg(3'd4, d); chk("R1 pin14 group1 R10", d, 8'h02);
    clear_all();
    toggle(23); rreg(3'd4, d); chk("R1 pin23 group2 R10", d, 8'h04);
    clear_all();
  endtask

  task automatic t_masked();
    logic [7:0] d;
    toggle(1); toggle(9); rreg(3'd4, d); chk("R5 masked pins", d, 8'h00);
    toggle(15); rreg(3'd4, d); chk("R2 pin15 absent", d, 8'h00);
  endtask

  task automatic t_request();
    logic [7:0] d;
    wreg(3'd3, 8'h05); gie = 1'b1;
    toggle(0); toggle(14);
    rreg(3'd4, d); chk("R10 two flags", d, 8'h03);
    #1 chk("R6 irq group gate", {5'd0, irq}, 8'h01);
    @(negedge clk); gie = 1'b0; #1 chk("R7 global off", {5'd0, irq}, 8'h00);
    toggle(23); rreg(3'd4, d); chk("R7 flags pend", d, 8'h07);
    @(negedge clk); gie = 1'b1; #1 chk("R7 released", {5'd0, irq}, 8'h05);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    @(negedge clk); ack = 3'b001;
    @(negedge clk); ack = '0;
    rreg(3'd4, d); chk("R8 ack clears R10", d, 8'h06);
    wreg(3'd4, 8'h00); rreg(3'd4, d); chk("R8 write zero", d, 8'h06);
    wreg(3'd4, 8'h04); rreg(3'd4, d); chk("R8 write one", d, 8'h02);
    clear_all();
  endtask

  task automatic t_collide();
    logic [7:0] d;
    toggle(0);
    @(negedge clk); pins[0] = ~pins[0];
    repeat (2) @(posedge clk);
    @(negedge clk); ack = 3'b001;
    @(negedge clk); ack = '0;
    rreg(3'd4, d); chk("R9 event kept on ack", d, 8'h01);
    toggle(0);
    @(negedge clk); pins[0] = ~pins[0];
    repeat (2) @(posedge clk);
    @(negedge clk); addr = 3'd4; wdata = 8'h01; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    rreg(3'd4, d); chk("R9 event kept on write", d, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_regs();
    wreg(3'd3, 8'h00); wreg(3'd1, 8'h00); wreg(3'd0, 8'h00); wreg(3'd2, 8'h00);
    t_edges(); t_masked(); t_request(); t_clear(); t_collide();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule